// File: doc/BRIEF.md
# Oversampling Converter Serial Port Sequencer

This block is the digital sequencer behind the serial port of a no-latency oversampling converter. It repeats a fixed cycle of three phases. First it converts: it counts modulator samples for a number of system clocks set by the selected oversampling ratio, and at the end it captures a result word from an upstream stub. Then it sleeps and holds that word for as long as the host keeps chip select high. Finally it shifts a 32-bit frame out to the host. At the end of the frame a new conversion begins on its own.

The port's chip select, serial clock and data input pins are asynchronous to the system clock. Each is passed through a two-flop synchronizer, and both serial clock edges are found from the synchronized copy. While the host reads a frame, it clocks a 5-bit speed code in on the data input, and that code sets the length of the very next conversion. Whenever the port is selected outside a readout, the data output carries a busy flag. The host can end a readout early by raising chip select.

Top module: `osr_serial_sequencer`

## Requirements
- R1: While reset is held and just after it is released, `busy` is 1 and `sdo_oe` is 0. The first conversion after reset lasts 256 × MOD_DIV system clocks.
- R2: A conversion selected by speed code k (1 ≤ k ≤ 10) lasts OSR × MOD_DIV system clocks, where OSR = 64 · 2^(k−1). That gives 64 for code 1 and 32768 for code 10.
- R3: When a conversion ends, `busy` falls and the block stays asleep for as long as chip select is high. The word it holds is the one `result_i` carried on the last conversion clock, and later changes on `result_i` do not alter it.
- R4: When chip select is low during sleep, the held word is shifted out on `sdo`, MSB first. The next bit appears after each falling edge of `sck`. `sdo_oe` is the inverse of the synchronized chip select.
- R5: A readout ends at the 32nd falling edge of `sck` or when chip select returns high, whichever comes first. `busy` rises at that point and a new conversion starts.
- R6: While a conversion runs and chip select is low, `sdo` is 1.
- R7: The speed code is taken from `sdi` on the first five rising edges of `sck` in a readout, MSB first. It applies to the conversion that follows that readout.
- R8: The block falls back to a default speed when fewer than five code bits were captured, or when the code is 0 or above 10. The default depends on the `sdi` level at the end of the readout: low selects OSR 256 and high selects OSR 32768. An `sdi` pin held static low or high therefore picks the fast or the slowest setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the modulator time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from host, active low, asynchronous |
| sck | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial speed-code input, asynchronous |
| result_i | input | FRAME_W | Result word from the filter stub |
| sdo | output | 1 | Serial data or busy status |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| busy | output | 1 | High while a conversion runs |

## Verification
A pin change reaches the state registers three system clocks after it happens: two synchronizer flops, then the edge-detect register. The bench therefore holds each serial clock half period for eight system clocks, and it samples `sdo` and `busy` only after that settling time, on falling clock edges. Conversion lengths are measured by counting the falling clock edges on which `busy` is high. After a readout that length equals OSR × MOD_DIV exactly. The first conversion after reset is one shorter, because the reset cycle already holds count zero. Each measured length is compared with the value the speed code or the fallback rule predicts.

// File: rtl/osr_seq_pkg.sv
package osr_seq_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OUT   = 2'd2
    } seq_state_e;

    localparam int CODE_W       = 5;
    localparam int NUM_SPEEDS   = 10;
    localparam int BASE_OSR_LOG = 6;   // fastest ratio is 2**6
    localparam int FAST_CODE    = 3;   // ratio 256
    localparam int SLOW_CODE    = 10;  // ratio 32768

endpackage

// File: rtl/osr_seq_sync.sv
module osr_seq_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/osr_speed_decode.sv
module osr_speed_decode
    import osr_seq_pkg::*;
#(
    parameter int MOD_DIV = 4,
    parameter int LEN_W   = 20
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              code_full_i,
    input  logic              sdi_level_i,
    output logic [LEN_W-1:0]  len_o
);
    logic [CODE_W-1:0] sel;

    always_comb begin
        if (code_full_i && code_i >= CODE_W'(1) && code_i <= CODE_W'(NUM_SPEEDS)) begin
            sel = code_i;
        end else if (sdi_level_i) begin
            sel = CODE_W'(SLOW_CODE);
        end else begin
            sel = CODE_W'(FAST_CODE);
        end
        len_o = LEN_W'(MOD_DIV) << (BASE_OSR_LOG - 1 + int'(sel));
    end
endmodule

// File: rtl/osr_serial_sequencer.sv
module osr_serial_sequencer
    import osr_seq_pkg::*;
#(
    parameter int MOD_DIV = 4,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] result_i,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               busy
);
    localparam int LEN_W = BASE_OSR_LOG + NUM_SPEEDS + $clog2(MOD_DIV + 1);
    localparam int BIT_W = $clog2(FRAME_W + 1);
    localparam int CN_W  = $clog2(CODE_W + 1);
    localparam logic [LEN_W-1:0] RESET_LEN = LEN_W'(MOD_DIV) << (BASE_OSR_LOG - 1 + FAST_CODE);

    typedef struct packed {
        seq_state_e         state;
        logic [LEN_W-1:0]   cnt;
        logic [LEN_W-1:0]   len;
        logic [FRAME_W-1:0] shreg;
        logic [CODE_W-1:0]  code;
        logic [CN_W-1:0]    code_n;
        logic [BIT_W-1:0]   bit_n;
        logic               sck_prev;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic [2:0]       pins_s;
    logic             cs_s, sck_s, sdi_s;
    logic             sck_rise, sck_fall;
    logic [LEN_W-1:0] next_len;

    osr_seq_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sck, sdi}),
        .q_o   (pins_s)
    );

    assign cs_s     = pins_s[2];
    assign sck_s    = pins_s[1];
    assign sdi_s    = pins_s[0];
    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;

    osr_speed_decode #(.MOD_DIV(MOD_DIV), .LEN_W(LEN_W)) i_decode (
        .code_i      (q.code),
        .code_full_i (q.code_n == CN_W'(CODE_W)),
        .sdi_level_i (sdi_s),
        .len_o       (next_len)
    );

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        case (q.state)
            ST_CONV: begin
                if (q.cnt == q.len - LEN_W'(1)) begin
                    d.state = ST_SLEEP;
                    d.cnt   = '0;
                    d.shreg = result_i;
                end else begin
                    d.cnt = q.cnt + LEN_W'(1);
                end
            end
            ST_SLEEP: begin
                if (!cs_s) begin
                    d.state  = ST_OUT;
                    d.bit_n  = '0;
                    d.code_n = '0;
                    d.code   = '0;
                end
            end
            ST_OUT: begin
                if (cs_s) begin
                    d.state = ST_CONV;
                    d.cnt   = '0;
                    d.len   = next_len;
                end else begin
                    if (sck_rise && q.code_n != CN_W'(CODE_W)) begin
                        d.code   = {q.code[CODE_W-2:0], sdi_s};
                        d.code_n = q.code_n + CN_W'(1);
                    end
                    if (sck_fall) begin
                        d.shreg = q.shreg << 1;
                        d.bit_n = q.bit_n + BIT_W'(1);
                        if (q.bit_n == BIT_W'(FRAME_W - 1)) begin
                            d.state = ST_CONV;
                            d.cnt   = '0;
                            d.len   = next_len;
                        end
                    end
                end
            end
            default: d.state = ST_CONV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_CONV;
            q.cnt      <= '0;
            q.len      <= RESET_LEN;
            q.shreg    <= '0;
            q.code     <= '0;
            q.code_n   <= '0;
            q.bit_n    <= '0;
            q.sck_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.state)
            ST_CONV: sdo = 1'b1;
            ST_OUT:  sdo = q.shreg[FRAME_W-1];
            default: sdo = 1'b0;
        endcase
    end

    assign sdo_oe = ~cs_s;
    assign busy   = (q.state == ST_CONV);

endmodule

// File: rtl/osr_seq_checker.sv
module osr_seq_checker
    import osr_seq_pkg::*;
#(
    parameter int LEN_W   = 20,
    parameter int BIT_W   = 6,
    parameter int FRAME_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_e       state_i,
    input logic             cs_s_i,
    input logic             sck_fall_i,
    input logic [LEN_W-1:0] cnt_i,
    input logic [LEN_W-1:0] len_i,
    input logic [BIT_W-1:0] bit_n_i,
    input logic             busy_i,
    input logic             sdo_i,
    input logic             sdo_oe_i
);
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_CONV || state_i == ST_SLEEP || state_i == ST_OUT);

    a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_CONV) |-> (cnt_i < len_i));

    a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SLEEP && cs_s_i) |=> (state_i == ST_SLEEP && !busy_i));

    a_r5_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_OUT && cs_s_i) |=> (busy_i && cnt_i == '0));

    a_r5_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_OUT && !cs_s_i && sck_fall_i && bit_n_i == BIT_W'(FRAME_W - 1))
        |=> busy_i);

    a_r6_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && sdo_oe_i) |-> sdo_i);
endmodule

bind osr_serial_sequencer osr_seq_checker #(
    .LEN_W   (LEN_W),
    .BIT_W   (BIT_W),
    .FRAME_W (FRAME_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (q.state),
    .cs_s_i     (cs_s),
    .sck_fall_i (sck_fall),
    .cnt_i      (q.cnt),
    .len_i      (q.len),
    .bit_n_i    (q.bit_n),
    .busy_i     (busy),
    .sdo_i      (sdo),
    .sdo_oe_i   (sdo_oe)
);

// File: tb/test_osr_serial_sequencer.sv
`timescale 1ns/1ps
module test_osr_serial_sequencer;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [31:0] result_i = 32'hA5C3_0F71;
    logic        sdo, sdo_oe, busy;

    int n_checks = 0;
    int n_fail = 0;
    int run_len = 0;
    int last_len = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    osr_serial_sequencer #(.MOD_DIV(DIV), .FRAME_W(32)) i_osr_serial_sequencer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .result_i(result_i), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0;
        end else if (busy) begin
            run_len = run_len + 1;
        end else if (run_len != 0) begin
            last_len = run_len;
            run_len = 0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for the running conversion to end and compare its length.
    task automatic wait_conv(input int exp_len, input string req);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(last_len == exp_len, req, last_len, exp_len);
    endtask

    // Read nbits of the frame; send code bits first, then hold sdi at tail.
    task automatic read_frame(input int nbits, input logic [4:0] code, input logic tail,
                              input logic [31:0] exp_word, input string req);
        logic [31:0] got = '0;
        logic [31:0] mask;
        cs_n = 1'b0;
        clks(8);
        check(sdo_oe == 1'b1, "R4 sdo_oe on select", sdo_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 5) ? code[4 - i] : tail;
            clks(8);
            got[31 - i] = sdo;
            sck = 1'b1;
            clks(8);
            sck = 1'b0;
        end
        clks(8);
        mask = 32'hFFFF_FFFF << (32 - nbits);
        check((got & mask) == (exp_word & mask), req, got & mask, exp_word & mask);
        if (nbits == 32) begin
            check(busy == 1'b1, "R5 busy after 32 bits", busy, 1);
            check(sdo == 1'b1, "R6 sdo busy status", sdo, 1);
        end
        cs_n = 1'b1;
        clks(6);
        if (nbits < 32) check(busy == 1'b1, "R5 busy after cs abort", busy, 1);
    endtask

    task automatic t_reset;
        clks(2);
        check(busy == 1'b1, "R1 busy in reset", busy, 1);
        check(sdo_oe == 1'b0, "R1 sdo_oe in reset", sdo_oe, 0);
        @(negedge clk); #2 rst_n = 1'b1;
        clks(2);
        check(busy == 1'b1, "R1 busy after release", busy, 1);
        // reset cycle already holds count zero, so one fewer edge is seen
        wait_conv(256 * DIV - 1, "R1 first conversion length");
    endtask

    task automatic t_sleep_hold;
        result_i = 32'h1234_5678;
        clks(1000);
        check(busy == 1'b0, "R3 still asleep", busy, 0);
        check(sdo_oe == 1'b0, "R3 sdo_oe off in sleep", sdo_oe, 0);
        read_frame(32, 5'd1, 1'b0, 32'hA5C3_0F71, "R3 R4 held word shifted MSB first");
        result_i = 32'h5A3C_F00E;
        wait_conv(64 * DIV, "R7 R2 code 1 length");
    endtask

    task automatic t_abort_code2;
        read_frame(10, 5'd2, 1'b0, 32'h5A3C_F00E, "R5 R4 prefix before abort");
        result_i = 32'h8001_7FFE;
        wait_conv(128 * DIV, "R7 R2 code 2 length after abort");
    endtask

    task automatic t_short_abort;
        read_frame(3, 5'd0, 1'b0, 32'h8001_7FFE, "R5 three-bit prefix");
        result_i = 32'h0F0F_F0F0;
        wait_conv(256 * DIV, "R8 fewer than five code bits, sdi low");
    endtask

    task automatic t_invalid_code;
        read_frame(32, 5'd15, 1'b0, 32'h0F0F_F0F0, "R4 frame with code 15");
        result_i = 32'hFFFF_0001;
        wait_conv(256 * DIV, "R8 code 15 falls back to fast");
    endtask

    task automatic t_code4;
        read_frame(32, 5'd4, 1'b0, 32'hFFFF_0001, "R4 frame with code 4");
        result_i = 32'h7654_3210;
        wait_conv(512 * DIV, "R2 code 4 length");
    endtask

    task automatic t_static_high;
        read_frame(32, 5'd31, 1'b1, 32'h7654_3210, "R4 frame with sdi high");
        wait_conv(32768 * DIV, "R8 static high selects slowest");
    endtask

    initial begin
        t_reset();
        t_sleep_hold();
        t_abort_code2();
        t_short_abort();
        t_invalid_code();
        t_code4();
        t_static_high();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule